// File: doc/BRIEF.md
# Multiplexed LED Digit Scanner with Pulse-Width Brightness

This block drives a time-multiplexed common-cathode LED display of four digit positions. A prescaled step tick advances a phase counter through 64 steps per digit slot; after the last step the scanner moves to the next digit. Within each slot the selected digit's cathode is enabled only for a programmable number of the 64 steps, so brightness is set by the intensity value and at least one step of every slot stays dark as an interdigit gap.

For each digit a mask bit chooses between a hexadecimal glyph, built from the low nibble of that digit's byte, and direct control of segments a to g. A separate eight-bit register of extra LEDs (decimal points or loose indicators) supplies two more anode lines, two bits per digit slot. A scan-limit value trims the number of visited slots, a power-down input darkens all outputs while the counters keep running, and a lamp-test input lights everything at a fixed duty of 28/64 across all four slots. A one-cycle strobe with the slot index marks the middle of each lit window so that a key matrix reader can sample its return lines while a cathode is held low.

Top module: `led_mux_scanner`

## Requirements
- R1: After reset the phase and slot counters are zero, `slot_idx_o` is 0 and `slot_valid_o` is low.
- R2: Each `tick_i` advances the phase by one; after phase 63 the phase returns to 0 and the slot moves to the next index, wrapping to 0 after the last scanned slot; outputs follow the counters in the same cycle the counters change.
- R3: The number of scanned slots is `scan_limit_i`+1; a slot index above the limit keeps every cathode off until the scan wraps.
- R4: The current slot's cathode (`digit_n_o[slot]`, active low) is on when the phase is below the duty, where duty equals `intensity_i` and an intensity of 0 counts as 1; phase 63 is therefore always dark, and when no cathode is on `segment_o` is 0.
- R5: At most one bit of `digit_n_o` is low at any time.
- R6: When `decode_mask_i[k]` is 1, digit k shows the hex glyph of byte bits 3..0 on `segment_o[6:0]`, bit 6 = a down to bit 0 = g, with glyphs 0=7E,1=30,2=6D,3=79,4=33,5=5B,6=5F,7=70,8=7F,9=7B,A=77,b=1F,C=4E,d=3D,E=4F,F=47 (hex); bits 7..4 are ignored.
- R7: When `decode_mask_i[k]` is 0, byte bits 6..0 of digit k drive `segment_o[6:0]` directly and bit 7 is ignored.
- R8: While slot k is lit, `segment_o[7]` = `extra_leds_i[k]` and `segment_o[8]` = `extra_leds_i[k+4]`.
- R9: With `shutdown_i` high and `test_i` low, all cathodes are off, `segment_o` is 0 and no strobe is issued, while the counters keep advancing.
- R10: With `test_i` high, all four slots are scanned regardless of the limit or power-down, every bit of `segment_o` is 1 in the lit window, and the duty is 28/64; clearing `test_i` restores the display from the unchanged inputs.
- R11: `slot_valid_o` pulses for exactly one cycle, in the cycle after the tick that moves the phase to duty/2 (rounded down) within a scanned, powered slot, and `slot_idx_o` then gives that slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Prescaled phase step strobe |
| digit_data_i | input | 32 | Four digit bytes, digit k in bits 8k+7..8k |
| extra_leds_i | input | 8 | Extra LED bits, two per slot |
| decode_mask_i | input | 4 | Per-digit hex decode select |
| intensity_i | input | 6 | Lit steps per slot (0 treated as 1) |
| scan_limit_i | input | 2 | Last scanned slot index |
| shutdown_i | input | 1 | Power-down, outputs dark |
| test_i | input | 1 | Lamp test override |
| digit_n_o | output | 4 | Active-low cathode enables |
| segment_o | output | 9 | Anode enables: a..g in 6..0, extra LEDs in 7 and 8 |
| slot_idx_o | output | 2 | Current slot index |
| slot_valid_o | output | 1 | Mid-window strobe for key sampling |

## Verification
The assertions watch, on every cycle, that no two cathodes are ever on together, that a dark cathode set implies dark anodes, that power-down without lamp test keeps everything dark, that lamp test drives all anodes whenever a cathode is on, that a limit of zero keeps the upper cathodes off, and that the strobe never lasts two cycles. The exact phase at which each cathode turns off, the slot order and wrap point, the glyph table, the extra-LED routing and the strobe's placement at half the duty can only be shown by the bench, which tracks the phase and slot from the ticks it issues and compares every output after every tick under random and corner-case settings.

// File: rtl/led_mux_pkg.sv
// Shared definitions for the LED scanner: segment count and the hex glyph table.
// Assumes glyph bit 6 is segment a and bit 0 is segment g.
package led_mux_pkg;

    localparam int GLYPH_W = 7;

    // Hex glyph lookup for one nibble
    function automatic logic [GLYPH_W-1:0] hex_glyph(input logic [3:0] nib);
        logic [GLYPH_W-1:0] g;
        case (nib)
            4'h0: g = 7'h7E;
            4'h1: g = 7'h30;
            4'h2: g = 7'h6D;
            4'h3: g = 7'h79;
            4'h4: g = 7'h33;
            4'h5: g = 7'h5B;
            4'h6: g = 7'h5F;
            4'h7: g = 7'h70;
            4'h8: g = 7'h7F;
            4'h9: g = 7'h7B;
            4'hA: g = 7'h77;
            4'hB: g = 7'h1F;
            4'hC: g = 7'h4E;
            4'hD: g = 7'h3D;
            4'hE: g = 7'h4F;
            default: g = 7'h47;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/mux_timer.sv
// Phase and slot counters of the scanner plus the mid-window strobe.
// Assumes DIGITS and STEPS are powers of two, DIGITS >= 2.
// The strobe is registered with the counters, so it lines up with the new phase.
module mux_timer #(
    parameter int DIGITS = 4,
    parameter int STEPS  = 64,
    localparam int SLOT_W = $clog2(DIGITS),
    localparam int PH_W   = $clog2(STEPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [SLOT_W-1:0] last_slot,
    input  logic [PH_W-1:0]   mid_phase,
    input  logic              strobe_en,
    output logic [SLOT_W-1:0] slot,
    output logic [PH_W-1:0]   phase,
    output logic              strobe
);

    logic [SLOT_W-1:0] slot_nxt;
    logic [PH_W-1:0]   phase_nxt;
    logic              slot_end;

    // Next-state of phase and slot for a tick
    always_comb begin
        slot_end  = (phase == PH_W'(STEPS - 1));
        phase_nxt = phase + 1'b1;
        slot_nxt  = slot;
        if (slot_end) begin
            slot_nxt = (slot >= last_slot) ? '0 : slot + 1'b1;
        end
    end

    // Counter registers, advanced only by the tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
            slot  <= '0;
        end else if (tick) begin
            phase <= phase_nxt;
            slot  <= slot_nxt;
        end
    end

    // One-cycle strobe when a tick lands on the window midpoint
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe <= 1'b0;
        end else begin
            strobe <= tick && strobe_en && (phase_nxt == mid_phase)
                      && (slot_nxt <= last_slot);
        end
    end

endmodule

// File: rtl/glyph_select.sv
// Builds the seven-segment pattern of every digit and picks the current one.
// Each digit is hex-decoded or passed raw according to its mask bit.
module glyph_select
    import led_mux_pkg::*;
#(
    parameter int DIGITS = 4,
    localparam int SLOT_W = $clog2(DIGITS)
) (
    input  logic [DIGITS*8-1:0] digit_data,
    input  logic [DIGITS-1:0]   decode_mask,
    input  logic [SLOT_W-1:0]   slot,
    output logic [GLYPH_W-1:0]  glyph
);

    logic [GLYPH_W-1:0] per_digit [DIGITS];

    for (genvar k = 0; k < DIGITS; k++) begin : g_digit
        logic [7:0] byte_k;
        assign byte_k = digit_data[k*8 +: 8];
        // Decoded or raw pattern of digit k
        always_comb begin
            if (decode_mask[k]) per_digit[k] = hex_glyph(byte_k[3:0]);
            else                per_digit[k] = byte_k[GLYPH_W-1:0];
        end
    end

    // Pattern of the slot being scanned
    always_comb begin
        glyph = per_digit[slot];
    end

endmodule

// File: rtl/pwm_gate.sv
// Turns the counters and control inputs into cathode and anode enables.
// Computes the duty, the lit window, the active slot range and the strobe point.
module pwm_gate
    import led_mux_pkg::*;
#(
    parameter int DIGITS    = 4,
    parameter int STEPS     = 64,
    parameter int TEST_DUTY = 28,
    localparam int SLOT_W   = $clog2(DIGITS),
    localparam int PH_W     = $clog2(STEPS),
    localparam int SEG_W    = GLYPH_W + 2
) (
    input  logic [SLOT_W-1:0]   slot,
    input  logic [PH_W-1:0]     phase,
    input  logic [PH_W-1:0]     intensity,
    input  logic [SLOT_W-1:0]   scan_limit,
    input  logic                shutdown,
    input  logic                lamp_test,
    input  logic [GLYPH_W-1:0]  glyph,
    input  logic [2*DIGITS-1:0] extra_leds,
    output logic [DIGITS-1:0]   digit_n,
    output logic [SEG_W-1:0]    segments,
    output logic [SLOT_W-1:0]   last_slot,
    output logic [PH_W-1:0]     mid_phase,
    output logic                powered
);

    logic [PH_W-1:0]   duty;
    logic              lit;
    logic [DIGITS-1:0] bank_lo;
    logic [DIGITS-1:0] bank_hi;

    // Duty, scan range and lit window
    always_comb begin
        powered   = lamp_test || !shutdown;
        last_slot = lamp_test ? SLOT_W'(DIGITS - 1) : scan_limit;
        if (lamp_test)              duty = PH_W'(TEST_DUTY);
        else if (intensity == '0)   duty = PH_W'(1);
        else                        duty = intensity;
        mid_phase = duty >> 1;
        lit       = powered && (slot <= last_slot) && (phase < duty);
    end

    assign bank_lo = extra_leds[DIGITS-1:0];
    assign bank_hi = extra_leds[2*DIGITS-1:DIGITS];

    // Anode pattern for the lit slot
    always_comb begin
        if (!lit)           segments = '0;
        else if (lamp_test) segments = '1;
        else                segments = {bank_hi[slot], bank_lo[slot], glyph};
    end

    for (genvar k = 0; k < DIGITS; k++) begin : g_cathode
        assign digit_n[k] = !(lit && (slot == SLOT_W'(k)));
    end

endmodule

// File: rtl/led_mux_scanner.sv
// Top of the multiplexed LED scanner: counters, glyph selection and PWM gating.
// Assumes tick_i is a single-cycle strobe from an external prescaler.
module led_mux_scanner #(
    parameter int DIGITS    = 4,
    parameter int STEPS     = 64,
    parameter int TEST_DUTY = 28,
    localparam int SLOT_W   = $clog2(DIGITS),
    localparam int PH_W     = $clog2(STEPS),
    localparam int SEG_W    = led_mux_pkg::GLYPH_W + 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_i,
    input  logic [DIGITS*8-1:0] digit_data_i,
    input  logic [2*DIGITS-1:0] extra_leds_i,
    input  logic [DIGITS-1:0]   decode_mask_i,
    input  logic [PH_W-1:0]     intensity_i,
    input  logic [SLOT_W-1:0]   scan_limit_i,
    input  logic                shutdown_i,
    input  logic                test_i,
    output logic [DIGITS-1:0]   digit_n_o,
    output logic [SEG_W-1:0]    segment_o,
    output logic [SLOT_W-1:0]   slot_idx_o,
    output logic                slot_valid_o
);

    logic [SLOT_W-1:0]              slot;
    logic [PH_W-1:0]                phase;
    logic [SLOT_W-1:0]              last_slot;
    logic [PH_W-1:0]                mid_phase;
    logic                           powered;
    logic [led_mux_pkg::GLYPH_W-1:0] glyph;

    mux_timer #(.DIGITS(DIGITS), .STEPS(STEPS)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_i),
        .last_slot (last_slot),
        .mid_phase (mid_phase),
        .strobe_en (powered),
        .slot      (slot),
        .phase     (phase),
        .strobe    (slot_valid_o)
    );

    glyph_select #(.DIGITS(DIGITS)) u_glyph (
        .digit_data  (digit_data_i),
        .decode_mask (decode_mask_i),
        .slot        (slot),
        .glyph       (glyph)
    );

    pwm_gate #(.DIGITS(DIGITS), .STEPS(STEPS), .TEST_DUTY(TEST_DUTY)) u_gate (
        .slot       (slot),
        .phase      (phase),
        .intensity  (intensity_i),
        .scan_limit (scan_limit_i),
        .shutdown   (shutdown_i),
        .lamp_test  (test_i),
        .glyph      (glyph),
        .extra_leds (extra_leds_i),
        .digit_n    (digit_n_o),
        .segments   (segment_o),
        .last_slot  (last_slot),
        .mid_phase  (mid_phase),
        .powered    (powered)
    );

    assign slot_idx_o = slot;

endmodule

// File: rtl/led_mux_scanner_chk.sv
// Property checker for the LED scanner, bound to the top module.
// Sees only the top-level ports.
module led_mux_scanner_chk #(
    parameter int DIGITS = 4,
    parameter int SEG_W  = 9,
    parameter int SLOT_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              shutdown_i,
    input logic              test_i,
    input logic [SLOT_W-1:0] scan_limit_i,
    input logic [DIGITS-1:0] digit_n_o,
    input logic [SEG_W-1:0]  segment_o,
    input logic              slot_valid_o
);

    // R5
    one_cathode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~digit_n_o));

    // R4
    dark_anodes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (digit_n_o == '1) |-> (segment_o == '0));

    // R9
    shutdown_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shutdown_i && !test_i) |-> (digit_n_o == '1 && !slot_valid_o));

    // R10
    lamp_test_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (test_i && digit_n_o != '1) |-> (segment_o == '1));

    // R3
    single_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!test_i && scan_limit_i == '0) |-> (digit_n_o[DIGITS-1:1] == '1));

    // R11
    strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_valid_o |=> !slot_valid_o);

endmodule

bind led_mux_scanner led_mux_scanner_chk #(
    .DIGITS(DIGITS), .SEG_W(SEG_W), .SLOT_W(SLOT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .shutdown_i   (shutdown_i),
    .test_i       (test_i),
    .scan_limit_i (scan_limit_i),
    .digit_n_o    (digit_n_o),
    .segment_o    (segment_o),
    .slot_valid_o (slot_valid_o)
);

// File: tb/tb_led_mux_scanner.sv
// Bench for the LED scanner: tracks phase and slot from its own ticks and
// compares every output after each tick against values from the requirements.
module tb_led_mux_scanner;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic [31:0] digit_data_i = '0;
    logic [7:0]  extra_leds_i = '0;
    logic [3:0]  decode_mask_i = '0;
    logic [5:0]  intensity_i = 6'd4;
    logic [1:0]  scan_limit_i = 2'd3;
    logic        shutdown_i = 1'b1;
    logic        test_i = 1'b0;
    logic [3:0]  digit_n_o;
    logic [8:0]  segment_o;
    logic [1:0]  slot_idx_o;
    logic        slot_valid_o;

    int checks = 0;
    int fails  = 0;
    int m_slot = 0;
    int m_phase = 0;
    bit done = 1'b0;

    led_mux_scanner dut (.*);

    always #4 clk = ~clk;

    function automatic logic [6:0] font(input logic [3:0] n);
        case (n)
            4'h0: return 7'b1111110; 4'h1: return 7'b0110000;
            4'h2: return 7'b1101101; 4'h3: return 7'b1111001;
            4'h4: return 7'b0110011; 4'h5: return 7'b1011011;
            4'h6: return 7'b1011111; 4'h7: return 7'b1110000;
            4'h8: return 7'b1111111; 4'h9: return 7'b1111011;
            4'hA: return 7'b1110111; 4'hB: return 7'b0011111;
            4'hC: return 7'b1001110; 4'hD: return 7'b0111101;
            4'hE: return 7'b1001111; default: return 7'b1000111;
        endcase
    endfunction

    function automatic int duty_of();
        if (test_i) return 28;
        if (intensity_i == 0) return 1;
        return int'(intensity_i);
    endfunction

    function automatic int last_of();
        return test_i ? 3 : int'(scan_limit_i);
    endfunction

    function automatic bit lit_now();
        return (test_i || !shutdown_i) && (m_slot <= last_of()) && (m_phase < duty_of());
    endfunction

    function automatic logic [3:0] exp_dig();
        return lit_now() ? ~(4'b0001 << m_slot) : 4'hF;
    endfunction

    function automatic logic [8:0] exp_seg();
        logic [7:0] b;
        logic [6:0] g;
        if (!lit_now()) return 9'h000;
        if (test_i) return 9'h1FF;
        b = digit_data_i[m_slot*8 +: 8];
        g = decode_mask_i[m_slot] ? font(b[3:0]) : b[6:0];
        return {extra_leds_i[m_slot+4], extra_leds_i[m_slot], g};
    endfunction

    task automatic cmp(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h (slot %0d phase %0d)",
                     req, what, act, exp, m_slot, m_phase);
        end
    endtask

    task automatic check_all(input string req, input bit exp_valid);
        cmp(req, "digit_n", int'(digit_n_o), int'(exp_dig()));
        cmp(req, "segment", int'(segment_o), int'(exp_seg()));
        cmp("R2", "slot_idx", int'(slot_idx_o), m_slot);
        cmp("R11", "slot_valid", int'(slot_valid_o), int'(exp_valid));
        if (!$onehot0(~digit_n_o)) cmp("R5", "one cathode", 0, 1);
    endtask

    // One tick followed by an idle cycle, with checks after each
    task automatic step(input string req);
        bit ev;
        tick_i = 1'b1;
        @(posedge clk);
        m_phase++;
        if (m_phase == 64) begin
            m_phase = 0;
            m_slot = (m_slot >= last_of()) ? 0 : m_slot + 1;
        end
        ev = (test_i || !shutdown_i) && (m_slot <= last_of()) && (m_phase == duty_of() / 2);
        @(negedge clk);
        tick_i = 1'b0;
        check_all(req, ev);
        @(negedge clk);
        check_all(req, 1'b0);
    endtask

    task automatic run_frame(input string req);
        step(req);
        while (!(m_slot == 0 && m_phase == 0)) step(req);
    endtask

    initial begin
        #(8 * 200000);
        cmp("R1", "watchdog", 0, 1);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        // R1: counters and strobe after reset
        check_all("R1", 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1", 1'b0);

        // R9: power-down keeps counting in the dark
        repeat (100) step("R9");

        // R6: every hex glyph, bits 7..4 set as noise
        shutdown_i = 1'b0;
        intensity_i = 6'd40;
        decode_mask_i = 4'hF;
        for (int n = 0; n < 16; n += 4) begin
            digit_data_i = {4'hA, 4'(n+3), 4'h5, 4'(n+2), 4'hF, 4'(n+1), 4'h9, 4'(n)};
            while (m_phase != 0) step("R6");
            run_frame("R6");
        end

        // R7: raw segments with bit 7 set; R8 extra LEDs
        decode_mask_i = 4'b0000;
        digit_data_i = 32'hAA_D5_FF_81;
        extra_leds_i = 8'b1001_0110;
        run_frame("R7");
        decode_mask_i = 4'b0101;
        extra_leds_i = 8'b0110_1001;
        run_frame("R8");

        // R4: intensity corners 0, 1, 63
        intensity_i = 6'd0;  run_frame("R4");
        intensity_i = 6'd1;  run_frame("R4");
        intensity_i = 6'd63; run_frame("R4");

        // R3: each scan limit
        for (int l = 0; l < 4; l++) begin
            scan_limit_i = 2'(l);
            run_frame("R3");
        end

        // R10: lamp test over power-down and a one-slot limit, then restore
        scan_limit_i = 2'd0;
        shutdown_i = 1'b1;
        test_i = 1'b1;
        run_frame("R10");
        test_i = 1'b0;
        shutdown_i = 1'b0;
        run_frame("R10");
        scan_limit_i = 2'd3;
        run_frame("R10");

        // R11/R2: random settings each frame
        for (int f = 0; f < 24; f++) begin
            digit_data_i = $urandom;
            extra_leds_i = 8'($urandom);
            decode_mask_i = 4'($urandom);
            intensity_i = 6'($urandom);
            scan_limit_i = 2'($urandom);
            shutdown_i = ($urandom % 8) == 0;
            test_i = ($urandom % 8) == 0;
            run_frame("R11");
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule